// File: doc/BRIEF.md
# Dual-Address Synchronous SRAM with Port-to-Port Forwarding

This block is a single-clock memory with two independent ports, called X and Y. Each port has its own address, its own write-data input, its own read-data output, an active-low write strobe and an active-low forwarding request. Two shared chip enables select the whole block. In one cycle the two ports can read, write, or send their incoming data straight to the other port's output register, in most combinations. Everything the block samples is captured on the rising clock edge. Results appear on the outputs one edge later, through output registers. The array holds 2^ADDR_W words of DATA_W bits. Setting ADDR_W to 16 and DATA_W to 18 gives the full 64K x 18 array. The smaller default keeps elaboration light.

The external bidirectional data pins are split into a data input, a data output and an output-enable signal for each port. The output enables are combinational copies of the active-low enable inputs, with no register in between. This lets a board-level or pad-level driver put the pin into high impedance at any time.

The two ports may target the same word in the same cycle. In that case fixed rules decide the result. Two reads both see the stored word. A read alongside a write on the other port returns the word as it was before the write. When both ports write, only port Y's data is kept.

Top module: `pt_dual_sram`

## Requirements
- R1: When the block is selected and a port's write strobe is low, that port's input data is stored at that port's address. A later read from either port at that address returns it.
- R2: Reads are pipelined. When selected, a port with its write strobe high reads only if neither forwarding request is low. The address is sampled at clock edge N, and the word appears on that port's output after edge N+1.
- R3: The block is selected only when ce1_n is 0 and ce2 is 1 at the sampling edge. In any other cycle, nothing is written, read or forwarded, and both outputs keep their values.
- R4: A low x_pass_n in a selected cycle loads x_din into port Y's output register. The value appears on y_dout with the same latency as a read.
- R5: A low y_pass_n in a selected cycle loads y_din into port X's output register, with the same latency.
- R6: Any low forwarding request suppresses the reads on both ports. A port that receives no forwarded data in that cycle keeps its previous output.
- R7: Both writes and both forwarding directions can occur in the same cycle, and all four take effect.
- R8: When both ports read the same address in the same cycle, both outputs show the stored word.
- R9: When one port writes an address and the other port reads the same address in the same cycle, the reader gets the word held before the write.
- R10: When both ports write the same address in the same cycle, the array keeps port Y's data.
- R11: A port's output holds its value in any cycle that has neither a read on that port nor data forwarded into it, for example a write-only cycle.
- R12: x_oe equals the inverse of x_oe_n, and y_oe equals the inverse of y_oe_n, at all times and with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the control registers |
| ce1_n | input | 1 | Chip enable, active low, registered |
| ce2 | input | 1 | Chip enable, active high, registered |
| x_addr | input | ADDR_W | Port X word address |
| x_din | input | DATA_W | Port X write / forwarding data |
| x_we_n | input | 1 | Port X write strobe, active low |
| x_pass_n | input | 1 | Port X forwarding request (X to Y), active low |
| x_oe_n | input | 1 | Port X output enable, active low, asynchronous |
| x_dout | output | DATA_W | Port X output register contents |
| x_oe | output | 1 | Port X pad drive enable (high = drive) |
| y_addr | input | ADDR_W | Port Y word address |
| y_din | input | DATA_W | Port Y write / forwarding data |
| y_we_n | input | 1 | Port Y write strobe, active low |
| y_pass_n | input | 1 | Port Y forwarding request (Y to X), active low |
| y_oe_n | input | 1 | Port Y output enable, active low, asynchronous |
| y_dout | output | DATA_W | Port Y output register contents |
| y_oe | output | 1 | Port Y pad drive enable (high = drive) |

## Verification
Two kinds of event can land in the same cycle: a write on one port together with a read of the same word on the other, and a forwarding request together with a read that it has to override. Directed cycles put each pairing on one address with hand-computed results. A long random phase then runs over a narrow address space, so that same-address collisions and mixed forwarding happen often. A behavioural model in the bench reads its stored words before it applies writes, and applies port Y's write last. Every cycle, the bench compares both outputs against this model.

// File: rtl/ptds_pkg.sv
package ptds_pkg;
  localparam int NPORT = 2;
  localparam int PX    = 0;
  localparam int PY    = 1;

  // per-port action for one selected cycle
  typedef struct packed {
    logic wr;      // store din at addr
    logic rd;      // load array word into output register
    logic fwd_in;  // load partner port's din into output register
  } port_act_t;
endpackage

// File: rtl/ptds_port_reg.sv
module ptds_port_reg #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              we_n_i,
  input  logic              pt_n_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q,
  output logic              we_n_q,
  output logic              pt_n_q
);
  // strobes reset to inactive; address/data need no reset
  always_ff @(posedge clk) begin
    if (rst) begin
      we_n_q <= 1'b1;
      pt_n_q <= 1'b1;
    end else begin
      we_n_q <= we_n_i;
      pt_n_q <= pt_n_i;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_i;
    din_q  <= din_i;
  end
endmodule

// File: rtl/ptds_decode.sv
module ptds_decode
  import ptds_pkg::*;
(
  input  logic                  sel,
  input  logic [NPORT-1:0]      we_n,
  input  logic [NPORT-1:0]      pt_n,
  output port_act_t [NPORT-1:0] act
);
  logic any_pt;

  always_comb begin
    // any forwarding request beats both reads
    any_pt = (pt_n != {NPORT{1'b1}});
    for (int p = 0; p < NPORT; p++) begin
      act[p].wr     = sel & ~we_n[p];
      act[p].rd     = sel & we_n[p] & ~any_pt;
      act[p].fwd_in = sel & ~pt_n[NPORT-1-p];
    end
  end
endmodule

// File: rtl/ptds_array.sv
module ptds_array
  import ptds_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic                         clk,
  input  logic [NPORT-1:0]             wr,
  input  logic [NPORT-1:0]             rd,
  input  logic [NPORT-1:0][ADDR_W-1:0] addr,
  input  logic [NPORT-1:0][DATA_W-1:0] wdata,
  output logic [NPORT-1:0][DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              x_blocked;

  // same-address double write: port Y keeps the word
  assign x_blocked = wr[PY] && (addr[PX] == addr[PY]);

  always_ff @(posedge clk) begin
    if (wr[PX] && !x_blocked) mem[addr[PX]] <= wdata[PX];
    if (wr[PY])               mem[addr[PY]] <= wdata[PY];
  end

  // registered read-first ports; nonblocking update gives old data
  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rd[p]) rdata[p] <= mem[addr[p]];
    end
  end
endmodule

// File: rtl/ptds_out_stage.sv
module ptds_out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              fwd_in,
  input  logic [DATA_W-1:0] fwd_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout
);
  logic              use_fwd;
  logic [DATA_W-1:0] fwd_q;

  always_ff @(posedge clk) begin
    if (rst)         use_fwd <= 1'b0;
    else if (fwd_in) use_fwd <= 1'b1;
    else if (rd)     use_fwd <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (fwd_in) fwd_q <= fwd_data;
  end

  assign dout = use_fwd ? fwd_q : rd_data;
endmodule

// File: rtl/pt_dual_sram.sv
module pt_dual_sram
  import ptds_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [DATA_W-1:0] x_din,
  input  logic              x_we_n,
  input  logic              x_pass_n,
  input  logic              x_oe_n,
  output logic [DATA_W-1:0] x_dout,
  output logic              x_oe,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic [DATA_W-1:0] y_din,
  input  logic              y_we_n,
  input  logic              y_pass_n,
  input  logic              y_oe_n,
  output logic [DATA_W-1:0] y_dout,
  output logic              y_oe
);
  logic [NPORT-1:0][ADDR_W-1:0] a_in, a_q;
  logic [NPORT-1:0][DATA_W-1:0] d_in, d_q, rd_q, q;
  logic [NPORT-1:0]             we_in, pt_in, we_q, pt_q, wr_v, rd_v;
  port_act_t [NPORT-1:0]        act;
  logic                         ce1_n_q, ce2_q, sel;

  assign a_in  = {y_addr, x_addr};
  assign d_in  = {y_din, x_din};
  assign we_in = {y_we_n, x_we_n};
  assign pt_in = {y_pass_n, x_pass_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      ce1_n_q <= 1'b1;
      ce2_q   <= 1'b0;
    end else begin
      ce1_n_q <= ce1_n;
      ce2_q   <= ce2;
    end
  end

  assign sel = ~ce1_n_q & ce2_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_in
    ptds_port_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
      .clk(clk), .rst(rst),
      .addr_i(a_in[p]), .din_i(d_in[p]), .we_n_i(we_in[p]), .pt_n_i(pt_in[p]),
      .addr_q(a_q[p]),  .din_q(d_q[p]),  .we_n_q(we_q[p]),  .pt_n_q(pt_q[p])
    );
  end

  ptds_decode u_dec (.sel(sel), .we_n(we_q), .pt_n(pt_q), .act(act));

  for (genvar p = 0; p < NPORT; p++) begin : g_act
    assign wr_v[p] = act[p].wr;
    assign rd_v[p] = act[p].rd;
  end

  ptds_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr(wr_v), .rd(rd_v), .addr(a_q), .wdata(d_q), .rdata(rd_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    ptds_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst(rst),
      .rd(act[p].rd), .fwd_in(act[p].fwd_in),
      .fwd_data(d_q[NPORT-1-p]), .rd_data(rd_q[p]),
      .dout(q[p])
    );
  end

  assign x_dout = q[PX];
  assign y_dout = q[PY];
  assign x_oe   = ~x_oe_n;
  assign y_oe   = ~y_oe_n;
endmodule

// File: rtl/pt_dual_sram_chk.sv
module pt_dual_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              ce1_n,
  input logic              ce2,
  input logic              x_we_n,
  input logic              y_we_n,
  input logic              x_pass_n,
  input logic              y_pass_n,
  input logic [DATA_W-1:0] x_din,
  input logic [DATA_W-1:0] y_din,
  input logic [DATA_W-1:0] x_dout,
  input logic [DATA_W-1:0] y_dout
);
  // R4
  x_to_y_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce1_n && ce2 && !x_pass_n) |-> ##2 (y_dout == $past(x_din, 2)));

  // R5
  y_to_x_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce1_n && ce2 && !y_pass_n) |-> ##2 (x_dout == $past(y_din, 2)));

  // R3
  deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ce1_n || !ce2) |-> ##2 ($stable(x_dout) && $stable(y_dout)));

  // R11
  x_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce1_n && ce2 && !x_we_n && y_pass_n) |-> ##2 $stable(x_dout));

  // R11
  y_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce1_n && ce2 && !y_we_n && x_pass_n) |-> ##2 $stable(y_dout));
endmodule

bind pt_dual_sram pt_dual_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2),
  .x_we_n(x_we_n), .y_we_n(y_we_n), .x_pass_n(x_pass_n), .y_pass_n(y_pass_n),
  .x_din(x_din), .y_din(y_din), .x_dout(x_dout), .y_dout(y_dout)
);

// File: tb/sim_pt_dual_sram.sv
`timescale 1ns/1ps
module sim_pt_dual_sram;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce1_n = 1'b1, ce2 = 1'b0;
  logic [AW-1:0] xa = '0, ya = '0;
  logic [DW-1:0] xd = '0, yd = '0;
  logic xw = 1'b1, yw = 1'b1, xp = 1'b1, yp = 1'b1, xoe_n = 1'b1, yoe_n = 1'b1;
  logic [DW-1:0] x_dout, y_dout;
  logic x_oe, y_oe;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pt_dual_sram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2),
    .x_addr(xa), .x_din(xd), .x_we_n(xw), .x_pass_n(xp), .x_oe_n(xoe_n),
    .x_dout(x_dout), .x_oe(x_oe),
    .y_addr(ya), .y_din(yd), .y_we_n(yw), .y_pass_n(yp), .y_oe_n(yoe_n),
    .y_dout(y_dout), .y_oe(y_oe)
  );

  // behavioural reference: words keyed by address, one-op pending stage
  logic [DW-1:0] mm [int];
  bit            pv;
  logic          p_c1, p_c2, p_xw, p_yw, p_xp, p_yp;
  logic [AW-1:0] p_xa, p_ya;
  logic [DW-1:0] p_xd, p_yd;
  bit            ex_v, ey_v;
  logic [DW-1:0] ex_val, ey_val;
  string         ex_tag = "R2", ey_tag = "R2";

  always @(posedge clk) begin
    if (rst) begin
      pv = 0; ex_v = 0; ey_v = 0;
    end else begin
      if (pv && !p_c1 && p_c2) begin
        bit kx, ky, anyp;
        logic [DW-1:0] ox, oy;
        kx = mm.exists(int'(p_xa)); ox = kx ? mm[int'(p_xa)] : '0;
        ky = mm.exists(int'(p_ya)); oy = ky ? mm[int'(p_ya)] : '0;
        anyp = !p_xp || !p_yp;
        if (!p_yp)              begin ex_v = 1; ex_val = p_yd; ex_tag = "R5"; end
        else if (p_xw && !anyp) begin ex_v = kx; ex_val = ox; ex_tag = "R2"; end
        else                    ex_tag = anyp ? "R6" : "R11";
        if (!p_xp)              begin ey_v = 1; ey_val = p_xd; ey_tag = "R4"; end
        else if (p_yw && !anyp) begin ey_v = ky; ey_val = oy; ey_tag = "R2"; end
        else                    ey_tag = anyp ? "R6" : "R11";
        if (!p_xw) mm[int'(p_xa)] = p_xd;
        if (!p_yw) mm[int'(p_ya)] = p_yd;  // Y applied last: R10
      end else if (pv) begin
        ex_tag = "R3"; ey_tag = "R3";
      end
      pv = 1;
      p_c1 = ce1_n; p_c2 = ce2; p_xa = xa; p_ya = ya; p_xd = xd; p_yd = yd;
      p_xw = xw; p_yw = yw; p_xp = xp; p_yp = yp;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go();
    @(negedge clk);
    if (ex_v) chk(ex_tag, x_dout, ex_val);
    if (ey_v) chk(ey_tag, y_dout, ey_val);
  endtask

  task automatic drive(input logic c1, input logic c2,
                       input logic [AW-1:0] a0, input logic [DW-1:0] d0, input logic w0, input logic p0,
                       input logic [AW-1:0] a1, input logic [DW-1:0] d1, input logic w1, input logic p1);
    go();
    ce1_n = c1; ce2 = c2;
    xa = a0; xd = d0; xw = w0; xp = p0;
    ya = a1; yd = d1; yw = w1; yp = p1;
  endtask

  task automatic idle();
    drive(1, 1, 0, 0, 1, 1, 0, 0, 1, 1);
  endtask

  task automatic settle();
    idle(); idle();
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL R2: watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12: enables follow their inputs without a clock
    xoe_n = 1'b0; yoe_n = 1'b1; #0.5;
    chk("R12", {17'd0, x_oe}, 18'd1);
    chk("R12", {17'd0, y_oe}, 18'd0);
    xoe_n = 1'b1; yoe_n = 1'b0; #0.5;
    chk("R12", {17'd0, x_oe}, 18'd0);
    chk("R12", {17'd0, y_oe}, 18'd1);

    // R1: write via X, read via Y
    drive(0, 1, 5, 18'h12345, 0, 1, 0, 0, 1, 1);
    drive(0, 1, 5, 0, 1, 1, 5, 0, 1, 1);
    settle();
    chk("R1", y_dout, 18'h12345);
    chk("R1", x_dout, 18'h12345);

    // R8: both read one word
    drive(0, 1, 7, 18'h0A1A1, 0, 1, 0, 0, 0, 1);
    drive(0, 1, 7, 0, 1, 1, 7, 0, 1, 1);
    settle();
    chk("R8", x_dout, 18'h0A1A1);
    chk("R8", y_dout, 18'h0A1A1);

    // R9: X writes, Y reads same word -> old data
    drive(0, 1, 7, 18'h0B2B2, 0, 1, 7, 0, 1, 1);
    settle();
    chk("R9", y_dout, 18'h0A1A1);
    drive(0, 1, 7, 0, 1, 1, 8, 0, 0, 1);
    settle();
    chk("R9", x_dout, 18'h0B2B2);

    // R10: both write same word -> Y kept
    drive(0, 1, 9, 18'h11111, 0, 1, 9, 18'h22222, 0, 1);
    drive(0, 1, 9, 0, 1, 1, 9, 0, 1, 1);
    settle();
    chk("R10", x_dout, 18'h22222);
    chk("R10", y_dout, 18'h22222);

    // R4 + R6: X forwards, X read suppressed
    drive(0, 1, 7, 18'h33333, 1, 0, 5, 0, 1, 1);
    settle();
    chk("R4", y_dout, 18'h33333);
    chk("R6", x_dout, 18'h22222);

    // R5 + R6: Y forwards, Y read suppressed
    drive(0, 1, 5, 0, 1, 1, 7, 18'h3C3C3, 1, 0);
    settle();
    chk("R5", x_dout, 18'h3C3C3);
    chk("R6", y_dout, 18'h33333);

    // R7: two writes and two forwards together
    drive(0, 1, 3, 18'h04444, 0, 0, 4, 18'h05555, 0, 0);
    settle();
    chk("R7", x_dout, 18'h05555);
    chk("R7", y_dout, 18'h04444);
    drive(0, 1, 3, 0, 1, 1, 4, 0, 1, 1);
    settle();
    chk("R7", x_dout, 18'h04444);
    chk("R7", y_dout, 18'h05555);

    // R3: deselected cycles do nothing
    drive(1, 1, 5, 18'h07777, 0, 0, 5, 18'h06666, 0, 0);
    drive(0, 0, 5, 18'h07777, 0, 0, 5, 18'h06666, 0, 0);
    settle();
    chk("R3", x_dout, 18'h04444);
    chk("R3", y_dout, 18'h05555);
    drive(0, 1, 5, 0, 1, 1, 5, 0, 1, 1);
    settle();
    chk("R3", x_dout, 18'h12345);
    chk("R3", y_dout, 18'h12345);

    // R11: write-only cycle holds both outputs
    drive(0, 1, 10, 18'h00001, 0, 1, 11, 18'h00002, 0, 1);
    settle();
    chk("R11", x_dout, 18'h12345);
    chk("R11", y_dout, 18'h12345);

    // random mix over a narrow address space; model compares each cycle
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 12) == 0, ($urandom % 12) != 0,
            AW'($urandom % 8), DW'($urandom), $urandom % 2, ($urandom % 5) != 0,
            AW'($urandom % 8), DW'($urandom), $urandom % 2, ($urandom % 5) != 0);
    end
    settle();
    go();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule